// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two equal-width buses, A and B, through a pair of independent storage registers. One register samples the A side on the rising edge of its own clock and can later deliver that value onto B. The other register samples the B side on its own clock and can deliver onto A. A per-direction select decides whether the driven bus carries the live value of the opposite bus or the stored register contents.

An active-low output enable and a direction input decide which bus, if any, is driven. With the enable high, both buses are released, but the registers still load on every clock edge. Each bidirectional bus is modelled as three vectors: an input, an output and an output enable. The enable is either all ones or all zeros, so an external resolver needs only to check one bit.

When a bus is driven, its register samples the value on the pin, which is the value the block itself is driving at that moment. An asynchronous active-low reset clears both registers and keeps both buses released. The two clocks are unrelated, and no synchronisation between them is needed.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On every rising edge of `clk_ab`, `hold_ab` loads the A pin value: `a_in` while A is not driven, `a_out` while it is driven.
- R2: On every rising edge of `clk_ba`, `hold_ba` loads the B pin value: `b_in` while B is not driven, `b_out` while it is driven.
- R3: Capture takes place regardless of `oe_n` and `dir`, and this includes isolation mode.
- R4: While `oe_n` is 1, both `a_oe` and `b_oe` are all zeros.
- R5: While `oe_n` is 0, `dir`=1 sets `b_oe` to all ones and `a_oe` to zeros. `dir`=0 sets `a_oe` to all ones and `b_oe` to zeros.
- R6: While B is driven, `b_out` equals `a_in` when `sel_ab`=0 and equals the A-to-B register when `sel_ab`=1.
- R7: While A is driven, `a_out` equals `b_in` when `sel_ba`=0 and equals the B-to-A register when `sel_ba`=1.
- R8: `a_oe` and `b_oe` are never both nonzero at the same time.
- R9: While `rst_n` is 0, both registers are zero and both enables are all zeros. Clock edges during reset load nothing.
- R10: A register whose bus is being driven captures the value the block itself drives onto that bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| oe_n | input | 1 | Active-low output enable for both buses |
| dir | input | 1 | 1: drive B, 0: drive A |
| sel_ab | input | 1 | B bus source: 0 live A, 1 stored A |
| sel_ba | input | 1 | A bus source: 0 live B, 1 stored B |
| a_in | input | W | Value seen on the A pins |
| a_out | output | W | Value driven onto A |
| a_oe | output | W | A drive enable, all ones or all zeros |
| b_in | input | W | Value seen on the B pins |
| b_out | output | W | Value driven onto B |
| b_oe | output | W | B drive enable, all ones or all zeros |

## Verification
The hardest case to reach from the ports is read-back capture. In this case a register loads the value that the block is driving onto its own bus, so that value differs from the external input sitting on the same pins. The stimulus drives B with the live A value while it pulses both clocks, and keeps a different value on `b_in` at the same time. It then turns the stored B value around onto A, and the register shows whether it took the driven value or the ignored input. A reset is also asserted in the middle of a stream, and a capture clock edge is given during that reset, to show that the cleared state survives.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  logic [W-1:0] hold_ab, hold_ba;
  logic         drive_a, drive_b;
  logic [W-1:0] a_pin, b_pin;

  assign drive_a = rst_n & ~oe_n & ~dir;
  assign drive_b = rst_n & ~oe_n &  dir;

  // Pin values built from inputs only, avoiding a combinational ring.
  assign a_pin = drive_a ? (sel_ba ? hold_ba : b_in) : a_in;
  assign b_pin = drive_b ? (sel_ab ? hold_ab : a_in) : b_in;

  assign a_out = sel_ba ? hold_ba : b_pin;
  assign b_out = sel_ab ? hold_ab : a_pin;
  assign a_oe  = {W{drive_a}};
  assign b_oe  = {W{drive_b}};

  always_ff @(posedge clk_ab or negedge rst_n)
    if (!rst_n) hold_ab <= '0;
    else        hold_ab <= a_pin;

  always_ff @(posedge clk_ba or negedge rst_n)
    if (!rst_n) hold_ba <= '0;
    else        hold_ba <= b_pin;

endmodule

module bus_xcvr_reg_chk #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         oe_n,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic [W-1:0] hold_ab,
  input logic [W-1:0] hold_ba
);

  a_r1_capture_a: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (a_oe == '0) |=> (hold_ab == $past(a_in)));

  a_r2_capture_b: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (b_oe == '0) |=> (hold_ba == $past(b_in)));

  a_r10_readback_a: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (|a_oe) |=> (hold_ab == $past(a_out)));

  a_r10_readback_b: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (|b_oe) |=> (hold_ba == $past(b_out)));

  a_r4_isolate: assert property (@(posedge clk_ab) disable iff (!rst_n)
    oe_n |-> (a_oe == '0 && b_oe == '0));

  a_r6_stored_to_b: assert property (@(posedge clk_ab) disable iff (!rst_n)
    ((|b_oe) && sel_ab) |-> (b_out == hold_ab));

  a_r7_stored_to_a: assert property (@(posedge clk_ba) disable iff (!rst_n)
    ((|a_oe) && sel_ba) |-> (a_out == hold_ba));

  a_r8_one_side_ab: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !((|a_oe) && (|b_oe)));

  a_r8_one_side_ba: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !((|a_oe) && (|b_oe)));

  a_r9_cleared: assert property (@(posedge clk_ab) disable iff (!rst_n)
    $rose(rst_n) |-> (hold_ab == '0));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (
  .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out),
  .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
  .hold_ab(hold_ab), .hold_ba(hold_ba)
);

// File: tb/bus_xcvr_reg_bench.sv
`timescale 1ns/1ps
module bus_xcvr_reg_bench;
  localparam int W = 8;

  typedef struct packed {
    logic oe_n, dir, sab, sba, pab, pba;
    logic [7:0] a, b;
    logic ea_oe, eb_oe;
    logic [7:0] ea, eb;
  } row_t;

  // oe_n dir sab sba pab pba  a  b  ea_oe eb_oe ea eb
  localparam row_t ROWS [14] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,8'h11,8'h22,1'b0,1'b0,8'h00,8'h00}, // R3 isolated capture both
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h33,8'h44,1'b0,1'b1,8'h00,8'h33}, // R6 live A to B
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h55,8'h44,1'b0,1'b1,8'h00,8'h11}, // R6 stored, R1
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h55,8'h66,1'b1,1'b0,8'h66,8'h00}, // R7 live B to A
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h55,8'h66,1'b1,1'b0,8'h22,8'h00}, // R7 stored, R2
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,8'h77,8'h88,1'b0,1'b0,8'h00,8'h00}, // R3 only A-side clock
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h99,8'h88,1'b0,1'b1,8'h00,8'h77}, // R1 new value stored
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h99,8'hAA,1'b1,1'b0,8'h22,8'h00}, // R2 B reg untouched
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,8'hC3,8'h5A,1'b0,1'b1,8'h00,8'hC3}, // R10 B reads back C3
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1,1'b0,8'hC3,8'h00}, // R10 stored readback
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,1'b1,8'h00,8'hC3}, // R1 A captured as input
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'hFF,8'h3C,1'b1,1'b0,8'h3C,8'h00}, // R10 A reads back 3C
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'hFF,8'h3C,1'b0,1'b1,8'h00,8'h3C}, // R10 shown on B
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,8'hFF,8'h3C,1'b0,1'b0,8'h00,8'h00}  // R4 dir ignored
  };

  logic tclk = 1'b0;
  logic rst_n, clk_ab, clk_ba, oe_n, dir, sel_ab, sel_ba;
  logic [W-1:0] a_in, a_out, a_oe, b_in, b_out, b_oe;
  int n_chk = 0, n_fail = 0, cycles = 0;

  always #2.5 tclk = ~tclk;

  bus_xcvr_reg #(.W(W)) u_bus_xcvr_reg (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic pab, input logic pba);
    #1 clk_ab = pab; clk_ba = pba;
    #1 clk_ab = 1'b0; clk_ba = 1'b0;
    #0.5;
  endtask

  always @(posedge tclk) begin
    cycles++;
    if (cycles > 5000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clk_ab = 1'b0; clk_ba = 1'b0; oe_n = 1'b0; dir = 1'b1;
    sel_ab = 1'b1; sel_ba = 1'b1; a_in = 8'hE1; b_in = 8'hE2;
    @(negedge tclk);
    pulse(1'b1, 1'b1);
    check("R9 reset a_oe", a_oe, '0);
    check("R9 reset b_oe", b_oe, '0);
    @(negedge tclk);
    rst_n = 1'b1;

    foreach (ROWS[i]) begin
      @(negedge tclk);
      oe_n = ROWS[i].oe_n; dir = ROWS[i].dir; sel_ab = ROWS[i].sab; sel_ba = ROWS[i].sba;
      a_in = ROWS[i].a; b_in = ROWS[i].b;
      pulse(ROWS[i].pab, ROWS[i].pba);
      check(ROWS[i].oe_n ? "R4 a_oe" : "R5 a_oe", a_oe, {W{ROWS[i].ea_oe}});
      check(ROWS[i].oe_n ? "R4 b_oe" : "R5 b_oe", b_oe, {W{ROWS[i].eb_oe}});
      check("R8 one side", {7'd0, (|a_oe) && (|b_oe)}, 8'd0);
      if (ROWS[i].ea_oe) check("R7 a_out", a_out, ROWS[i].ea);
      if (ROWS[i].eb_oe) check("R6 b_out", b_out, ROWS[i].eb);
    end

    // R9: mid-run reset clears stored values and ignores a clock edge
    @(negedge tclk);
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; a_in = 8'hEE;
    #1 check("R6 stored before reset", b_out, 8'h3C);
    rst_n = 1'b0;
    #0.5 check("R9 b_oe in reset", b_oe, '0);
    check("R9 a_oe in reset", a_oe, '0);
    pulse(1'b1, 1'b1);
    @(negedge tclk);
    rst_n = 1'b1;
    #1 check("R9 A-to-B register cleared", b_out, 8'h00);
    dir = 1'b0; sel_ba = 1'b1;
    #1 check("R9 B-to-A register cleared", a_out, 8'h00);
    check("R5 a_oe after reset", a_oe, '1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule